// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block moves 8-bit words between two ports, A and B, in either direction or both at once. Each direction owns a capture register with its own capture clock: a rising edge on the A-to-B clock stores whatever port A currently presents, and a rising edge on the B-to-A clock stores port B. Storing happens whether or not the direction is selected or enabled, so a word can be parked early and released later.

Each direction has a select that chooses what its destination port is given: the live value of the opposite port (real-time mode) or the stored register (storage mode). Each direction also has an output enable; the A-to-B enable is active high and the B-to-A enable is active low. A port is modelled as a separate input, output and output-enable trio rather than a bidirectional pin. The value a port effectively carries is its own output when that output is enabled, and its input otherwise. When both directions are enabled and both run in real time, each side drives back the other, and the pair holds the last bus value seen before the loop closed, without using the capture registers.

Top module: `dual_reg_xcvr`

## Requirements
- R1: Transfer is non-inverting and 8 bits wide in both directions; bit k of a source always lands on bit k of the destination.
- R2: A rising edge of clk_ab stores a_in in the A register and a rising edge of clk_ba stores b_in in the B register, whatever the values of sel_ab, sel_ba, en_ab and en_ba_n.
- R3: With sel_ab low, b_out carries the effective A value (real-time); with sel_ab high, b_out carries the A register (storage). sel_ba does the same for a_out, using the effective B value and the B register.
- R4: en_ab is active high; while it is low b_oe is 0 and b_out is all zeros.
- R5: en_ba_n is active low; while it is high a_oe is 0 and a_out is all zeros.
- R6: A port's effective value is its own output while its output enable is 1 and its input otherwise, so with both sides enabled, one in storage and one in real-time, both outputs show the same stored word.
- R7: With en_ab=1, en_ba_n=0, sel_ab=0 and sel_ba=0 both outputs equal the effective A value present just before this condition arose, and stay there while a_in and b_in change, until the condition ends.
- R8: An asynchronous active-low rst_n clears both capture registers and the held loop value to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_ab | input | 1 | Capture clock for the A register (rising edge) |
| clk_ba | input | 1 | Capture clock for the B register (rising edge) |
| sel_ab | input | 1 | B-side source: 0 real-time, 1 stored A register |
| sel_ba | input | 1 | A-side source: 0 real-time, 1 stored B register |
| en_ab | input | 1 | Drive enable toward port B, active high |
| en_ba_n | input | 1 | Drive enable toward port A, active low |
| a_in | input | 8 | Value applied to port A from outside |
| a_out | output | 8 | Value this block drives onto port A |
| a_oe | output | 1 | Port A output enable |
| b_in | input | 8 | Value applied to port B from outside |
| b_out | output | 8 | Value this block drives onto port B |
| b_oe | output | 1 | Port B output enable |

## Verification
A capture edge and a switch of the same direction's select from real-time to storage can arrive in one step, and then the destination port must show the freshly stored word at once rather than the old register or the live input. The bench holds the data stable for a step, then raises the capture clock and the select together and expects the new word immediately; it does the same for both directions and checks that a following change of the input leaves the stored output alone.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  localparam int DATA_W = 8;

  // Source chosen for one port's output
  typedef enum logic [2:0] {
    SRC_OFF,      // output disabled, drive zeros
    SRC_HOLD,     // both sides live and enabled: loop holds
    SRC_OWN_REG,  // storage mode: this direction's register
    SRC_FAR_REG,  // live, but the far port is itself driven from its register
    SRC_LIVE      // live, far port is an external input
  } src_e;

  function automatic logic loop_closed(input logic en_ab, input logic en_ba_n,
                                       input logic sel_ab, input logic sel_ba);
    return en_ab & ~en_ba_n & ~sel_ab & ~sel_ba;
  endfunction

  function automatic src_e out_src(input logic oe, input logic sel,
                                   input logic closed, input logic far_oe);
    if (!oe)         return SRC_OFF;
    else if (closed) return SRC_HOLD;
    else if (sel)    return SRC_OWN_REG;
    else if (far_oe) return SRC_FAR_REG;
    else             return SRC_LIVE;
  endfunction

endpackage

// File: rtl/cap_reg.sv
module cap_reg #(
  parameter int W = 8
) (
  input  logic         rst_n,
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/loop_hold.sv
module loop_hold #(
  parameter int W = 8
) (
  input  logic         rst_n,
  input  logic         en_ab,
  input  logic         en_ba_n,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic [W-1:0] reg_a,
  input  logic [W-1:0] reg_b,
  output logic [W-1:0] hold_q
);
  // Closure test and tracked value are formed from the raw inputs inside one
  // process, so the latch never samples a value formed with the loop closed.
  always_latch begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (!xcvr_pkg::loop_closed(en_ab, en_ba_n, sel_ab, sel_ba)) begin
      if (en_ba_n)     hold_q <= a_in;
      else if (sel_ba) hold_q <= reg_b;
      else if (en_ab)  hold_q <= reg_a;
      else             hold_q <= b_in;
    end
  end
endmodule

// File: rtl/port_mux.sv
module port_mux #(
  parameter int W = 8
) (
  input  logic         oe,
  input  logic         sel,
  input  logic         closed,
  input  logic         far_oe,
  input  logic [W-1:0] live_in,
  input  logic [W-1:0] own_reg,
  input  logic [W-1:0] far_reg,
  input  logic [W-1:0] hold_val,
  output logic [W-1:0] dout
);
  xcvr_pkg::src_e src;

  always_comb begin
    src = xcvr_pkg::out_src(oe, sel, closed, far_oe);
    unique case (src)
      xcvr_pkg::SRC_HOLD:    dout = hold_val;
      xcvr_pkg::SRC_OWN_REG: dout = own_reg;
      xcvr_pkg::SRC_FAR_REG: dout = far_reg;
      xcvr_pkg::SRC_LIVE:    dout = live_in;
      default:               dout = '0;
    endcase
  end
endmodule

// File: rtl/dual_reg_xcvr.sv
module dual_reg_xcvr #(
  parameter int W = xcvr_pkg::DATA_W
) (
  input  logic         rst_n,
  input  logic         clk_ab,
  input  logic         clk_ba,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic         en_ab,
  input  logic         en_ba_n,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_oe
);
  localparam int NDIR = 2;  // index 0: A-to-B, index 1: B-to-A

  logic            cap_clk [NDIR];
  logic [W-1:0]    cap_d   [NDIR];
  logic [W-1:0]    cap_q   [NDIR];
  logic            dir_oe  [NDIR];
  logic            dir_sel [NDIR];
  logic [W-1:0]    dir_src [NDIR];
  logic [W-1:0]    dir_out [NDIR];
  logic [W-1:0]    hold_val;
  logic            loop_is_closed;

  assign cap_clk[0] = clk_ab;
  assign cap_clk[1] = clk_ba;
  assign cap_d[0]   = a_in;
  assign cap_d[1]   = b_in;
  assign dir_oe[0]  = en_ab;
  assign dir_oe[1]  = ~en_ba_n;
  assign dir_sel[0] = sel_ab;
  assign dir_sel[1] = sel_ba;
  assign dir_src[0] = a_in;
  assign dir_src[1] = b_in;

  assign loop_is_closed = xcvr_pkg::loop_closed(en_ab, en_ba_n, sel_ab, sel_ba);

  for (genvar g = 0; g < NDIR; g++) begin : g_dir
    cap_reg #(.W(W)) u_reg (
      .rst_n (rst_n),
      .clk   (cap_clk[g]),
      .d     (cap_d[g]),
      .q     (cap_q[g])
    );
    port_mux #(.W(W)) u_mux (
      .oe       (dir_oe[g]),
      .sel      (dir_sel[g]),
      .closed   (loop_is_closed),
      .far_oe   (dir_oe[NDIR-1-g]),
      .live_in  (dir_src[g]),
      .own_reg  (cap_q[g]),
      .far_reg  (cap_q[NDIR-1-g]),
      .hold_val (hold_val),
      .dout     (dir_out[g])
    );
  end

  loop_hold #(.W(W)) u_hold (
    .rst_n   (rst_n),
    .en_ab   (en_ab),
    .en_ba_n (en_ba_n),
    .sel_ab  (sel_ab),
    .sel_ba  (sel_ba),
    .a_in    (a_in),
    .b_in    (b_in),
    .reg_a   (cap_q[0]),
    .reg_b   (cap_q[1]),
    .hold_q  (hold_val)
  );

  assign b_out = dir_out[0];
  assign b_oe  = dir_oe[0];
  assign a_out = dir_out[1];
  assign a_oe  = dir_oe[1];
endmodule

// File: rtl/xcvr_chk.sv
module xcvr_chk #(
  parameter int W = 8
) (
  input logic         rst_n,
  input logic         clk_ab,
  input logic         clk_ba,
  input logic         sel_ab,
  input logic         sel_ba,
  input logic         en_ab,
  input logic         en_ba_n,
  input logic [W-1:0] a_in,
  input logic [W-1:0] a_out,
  input logic         a_oe,
  input logic [W-1:0] b_in,
  input logic [W-1:0] b_out,
  input logic         b_oe
);
  logic seen_ab, seen_ba;
  logic both_live_on;

  assign both_live_on = en_ab && !en_ba_n && !sel_ab && !sel_ba;

  always_ff @(posedge clk_ab or negedge rst_n) begin
    if (!rst_n) seen_ab <= 1'b0;
    else        seen_ab <= 1'b1;
  end

  always_ff @(posedge clk_ba or negedge rst_n) begin
    if (!rst_n) seen_ba <= 1'b0;
    else        seen_ba <= 1'b1;
  end

  // R4
  b_quiet_chk: assert property (@(posedge clk_ab) disable iff (!rst_n)
    !en_ab |-> (!b_oe && b_out == '0));

  // R5
  a_quiet_chk: assert property (@(posedge clk_ba) disable iff (!rst_n)
    en_ba_n |-> (!a_oe && a_out == '0));

  // R3
  b_live_chk: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (en_ab && !sel_ab && en_ba_n) |-> b_out == a_in);

  // R3
  a_live_chk: assert property (@(posedge clk_ba) disable iff (!rst_n)
    (!en_ba_n && !sel_ba && !en_ab) |-> a_out == b_in);

  // R2
  b_stored_chk: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (seen_ab && en_ab && sel_ab) |-> b_out == $past(a_in));

  // R2
  a_stored_chk: assert property (@(posedge clk_ba) disable iff (!rst_n)
    (seen_ba && !en_ba_n && sel_ba) |-> a_out == $past(b_in));

  // R6
  mixed_agree_chk: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (en_ab && !en_ba_n && (sel_ab != sel_ba)) |-> a_out == b_out);

  // R7
  loop_agree_chk: assert property (@(posedge clk_ba) disable iff (!rst_n)
    both_live_on |-> (a_oe && b_oe && a_out == b_out));
endmodule

bind dual_reg_xcvr xcvr_chk #(.W(W)) u_chk (
  .rst_n   (rst_n),
  .clk_ab  (clk_ab),
  .clk_ba  (clk_ba),
  .sel_ab  (sel_ab),
  .sel_ba  (sel_ba),
  .en_ab   (en_ab),
  .en_ba_n (en_ba_n),
  .a_in    (a_in),
  .a_out   (a_out),
  .a_oe    (a_oe),
  .b_in    (b_in),
  .b_out   (b_out),
  .b_oe    (b_oe)
);

// File: tb/tb_dual_reg_xcvr.sv
`timescale 1ns/1ps
module tb_dual_reg_xcvr;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         clk_ab = 1'b0, clk_ba = 1'b0;
  logic         sel_ab = 1'b0, sel_ba = 1'b0;
  logic         en_ab = 1'b0, en_ba_n = 1'b1;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic         a_oe, b_oe;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  typedef struct {
    string        tag;
    logic         x_a_oe;
    logic [W-1:0] x_a_out;
    logic         x_b_oe;
    logic [W-1:0] x_b_out;
  } exp_t;

  exp_t sb_q[$];

  dual_reg_xcvr #(.W(W)) dut (
    .rst_n(rst_n), .clk_ab(clk_ab), .clk_ba(clk_ba),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .en_ab(en_ab), .en_ba_n(en_ba_n),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  always #2.5 clk = ~clk;

  task automatic drv(input string tag,
                     input logic eab, input logic ebn, input logic sab, input logic sba,
                     input logic pab, input logic pba,
                     input logic [W-1:0] ai, input logic [W-1:0] bi,
                     input logic xao, input logic [W-1:0] xa,
                     input logic xbo, input logic [W-1:0] xb);
    exp_t e;
    @(posedge clk);
    a_in = ai; b_in = bi;
    en_ab = eab; en_ba_n = ebn; sel_ab = sab; sel_ba = sba;
    clk_ab = pab; clk_ba = pba;
    e.tag = tag; e.x_a_oe = xao; e.x_a_out = xa; e.x_b_oe = xbo; e.x_b_out = xb;
    sb_q.push_back(e);
  endtask

  // Monitor: compares at the falling edge, away from all stimulus changes
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_checks++;
      if (a_oe !== e.x_a_oe || a_out !== e.x_a_out ||
          b_oe !== e.x_b_oe || b_out !== e.x_b_out) begin
        n_fail++;
        $display("FAIL %s: actual a_oe=%0b a_out=%02h b_oe=%0b b_out=%02h expected a_oe=%0b a_out=%02h b_oe=%0b b_out=%02h",
                 e.tag, a_oe, a_out, b_oe, b_out, e.x_a_oe, e.x_a_out, e.x_b_oe, e.x_b_out);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog: actual cycles=%0d expected completion", cycles);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    //   tag                       eab ebn sab sba pab pba  a_in   b_in   aoe a_out  boe b_out
    drv("R8 idle after reset",      0,  1,  0,  0,  0,  0, 8'h00, 8'h00, 0, 8'h00, 0, 8'h00);
    drv("R8 registers cleared",     1,  0,  1,  1,  0,  0, 8'h11, 8'h22, 1, 8'h00, 1, 8'h00);
    drv("R3 r1_ live A to B",       1,  1,  0,  0,  0,  0, 8'h5A, 8'h66, 0, 8'h00, 1, 8'h5A);
    drv("R3 r1_ live B to A",       0,  0,  0,  0,  0,  0, 8'h5A, 8'h66, 1, 8'h66, 0, 8'h00);
    drv("R4 R5 both disabled",      0,  1,  0,  0,  0,  0, 8'hA5, 8'h3C, 0, 8'h00, 0, 8'h00);
    drv("R2 capture while off",     0,  1,  0,  0,  1,  1, 8'hA5, 8'h3C, 0, 8'h00, 0, 8'h00);
    drv("R4 R5 outputs stay off",   0,  1,  0,  0,  0,  0, 8'hA5, 8'h3C, 0, 8'h00, 0, 8'h00);
    drv("R2 stored both ways",      1,  0,  1,  1,  0,  0, 8'h00, 8'hFF, 1, 8'h3C, 1, 8'hA5);
    drv("R6 B stored, A live",      1,  0,  1,  0,  0,  0, 8'h00, 8'hFF, 1, 8'hA5, 1, 8'hA5);
    drv("R6 A stored, B live",      1,  0,  0,  1,  0,  0, 8'h00, 8'hFF, 1, 8'h3C, 1, 8'h3C);
    drv("R3 live before capture",   1,  1,  0,  0,  0,  0, 8'hC7, 8'hFF, 0, 8'h00, 1, 8'hC7);
    drv("R2 capture with select",   1,  1,  1,  0,  1,  0, 8'hC7, 8'hFF, 0, 8'h00, 1, 8'hC7);
    drv("R3 storage ignores a_in",  1,  1,  1,  0,  0,  0, 8'h18, 8'hFF, 0, 8'h00, 1, 8'hC7);
    drv("R3 live B before capture", 0,  0,  0,  0,  0,  0, 8'h18, 8'h81, 1, 8'h81, 0, 8'h00);
    drv("R2 B capture with select", 0,  0,  0,  1,  0,  1, 8'h18, 8'h81, 1, 8'h81, 0, 8'h00);
    drv("R3 storage ignores b_in",  0,  0,  0,  1,  0,  0, 8'h18, 8'h00, 1, 8'h81, 0, 8'h00);
    drv("R7 before closing",        1,  1,  0,  0,  0,  0, 8'h5A, 8'h00, 0, 8'h00, 1, 8'h5A);
    drv("R7 loop closes",           1,  0,  0,  0,  0,  0, 8'h5A, 8'h00, 1, 8'h5A, 1, 8'h5A);
    drv("R7 inputs ignored",        1,  0,  0,  0,  0,  0, 8'hC3, 8'h11, 1, 8'h5A, 1, 8'h5A);
    drv("R7 loop opens",            0,  0,  0,  0,  0,  0, 8'hC3, 8'h11, 1, 8'h11, 0, 8'h00);
    drv("R7 recloses on B value",   1,  0,  0,  0,  0,  0, 8'hC3, 8'h11, 1, 8'h11, 1, 8'h11);
    drv("R7 held again",            1,  0,  0,  0,  0,  0, 8'h77, 8'h99, 1, 8'h11, 1, 8'h11);
    drv("R6 leave loop to storage", 1,  0,  1,  0,  0,  0, 8'h77, 8'h99, 1, 8'hC7, 1, 8'hC7);
    drv("R1 bit order 01",          1,  1,  0,  0,  0,  0, 8'h01, 8'h00, 0, 8'h00, 1, 8'h01);
    drv("R1 bit order 80",          0,  0,  0,  0,  0,  0, 8'h00, 8'h80, 1, 8'h80, 0, 8'h00);
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b0;
    drv("R8 async clear",           1,  0,  1,  1,  0,  0, 8'h42, 8'h24, 1, 8'h00, 1, 8'h00);
    @(posedge clk);
    rst_n = 1'b1;
    drv("R8 registers stay clear",  1,  0,  1,  1,  0,  0, 8'h42, 8'h24, 1, 8'h00, 1, 8'h00);
    drv("R8 hold tracks after",     1,  0,  0,  0,  0,  0, 8'h42, 8'h24, 1, 8'h00, 1, 8'h00);
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule